// File: doc/BRIEF.md
# Double-Buffered Timer Compare Channel

This block is one compare channel that sits beside a 16-bit up/down timer counter. Software loads a 16-bit compare value through an 8-bit register bus. The high byte is parked in a temporary register. The low-byte write then moves the full value across in one step, so the counter never sees a half-written value. An equality comparator checks the counter against the active compare value on every timer tick. A hit produces a match strobe for the waveform logic, and one tick later it sets a sticky flag that can raise an interrupt request.

In the pulse-width modes the written value lands in a buffer. It reaches the active register only when the counter sits at the chosen extreme (top or bottom) on a timer tick, so the period and duty cycle change cleanly. In the plain-count mode and the clear-on-compare modes the buffer is bypassed. When the channel is built as the period source, its active value is also driven out as the counter's top limit.

Top module: `ocu_channel`

## Requirements
- R1: After reset, cmp_o, top_o, flag_o, irq_o and match_o are all 0, and the interrupt enable is 0.
- R2: match_o is 1 exactly in cycles where tick_i is 1 and cnt_i equals cmp_o.
- R3: flag_o becomes 1 at the first tick_i cycle after a tick on which cnt_i equalled cmp_o. It is visible after that tick's clock edge.
- R4: irq_o equals flag_o AND the interrupt enable. The interrupt enable is bit 0 of a write to address 3.
- R5: A cycle with irq_ack_i high clears flag_o.
- R6: A write to address 2 with bit 0 set clears flag_o. A write to address 2 with bit 0 clear leaves flag_o unchanged.
- R7: When a flag set and a flag clear (acknowledge or software write) fall in the same cycle, the flag stays 1.
- R8: A write to address 1 stores the high byte in a temporary register and leaves cmp_o unchanged.
- R9: A write to address 0 forms {temporary byte, data}. In the unbuffered mode codes 0, 4 and 12 of wgm_i, that value appears on cmp_o after the write's clock edge.
- R10: For any other wgm_i code, a write to address 0 leaves cmp_o unchanged. The buffered value is copied to cmp_o on a tick_i cycle with at_top_i high when commit_top_i is 1, or with at_bottom_i high when commit_top_i is 0.
- R11: In buffered modes, the extreme that commit_top_i does not select, or a selected extreme without tick_i, does not change cmp_o.
- R12: With TOP_SRC=1, top_o equals cmp_o. With TOP_SRC=0, top_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer-clock enable strobe |
| cnt_i | input | 16 | Current counter value |
| at_top_i | input | 1 | Counter is at its top value |
| at_bottom_i | input | 1 | Counter is at zero |
| wgm_i | input | 4 | Waveform mode code |
| commit_top_i | input | 1 | 1: commit buffer at top, 0: at bottom |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | 0 low byte, 1 high byte, 2 flag clear, 3 control |
| wr_data_i | input | 8 | Register write data |
| irq_ack_i | input | 1 | Interrupt acknowledge |
| match_o | output | 1 | Compare match strobe to waveform logic |
| flag_o | output | 1 | Sticky compare flag |
| irq_o | output | 1 | Interrupt request |
| cmp_o | output | 16 | Active compare value |
| top_o | output | 16 | Counter top value when this channel sets the period |

## Verification
The bench writes a buffered value and then pulses the extreme that commit_top_i does not select, and a selected extreme without a tick. A design that commits on any extreme, or ignores the tick, changes cmp_o too early. It checks that the flag is still clear one edge after the matching tick, which catches a flag set in the same cycle as the match. It checks that a high-byte write alone leaves cmp_o unchanged, which exposes a design without the temporary register. It keeps a match running while clearing the flag, which reveals a design that lets the clear win over the set.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [1:0] {
    ADR_LO   = 2'd0,
    ADR_HI   = 2'd1,
    ADR_FLAG = 2'd2,
    ADR_CTRL = 2'd3
  } ocu_addr_e;

  // plain count and clear-on-compare codes bypass the buffer
  function automatic logic is_buffered(input logic [3:0] mode);
    return !(mode == 4'd0 || mode == 4'd4 || mode == 4'd12);
  endfunction
endpackage

// File: rtl/ocu_regif.sv
module ocu_regif import ocu_pkg::*; #(
  parameter int BUS_W = 8,
  localparam int W = 2 * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [BUS_W-1:0] wr_data_i,
  output logic             wr16_o,
  output logic [W-1:0]     val16_o,
  output logic             sw_clr_o,
  output logic             ie_o
);
  logic [BUS_W-1:0] temp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q <= '0;
      ie_o   <= 1'b0;
    end else if (wr_en_i) begin
      if (wr_addr_i == ADR_HI)   temp_q <= wr_data_i;
      if (wr_addr_i == ADR_CTRL) ie_o   <= wr_data_i[0];
    end
  end

  assign wr16_o   = wr_en_i && (wr_addr_i == ADR_LO);
  assign val16_o  = {temp_q, wr_data_i};
  assign sw_clr_o = wr_en_i && (wr_addr_i == ADR_FLAG) && wr_data_i[0];
endmodule

// File: rtl/ocu_buffer.sv
module ocu_buffer import ocu_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         at_top_i,
  input  logic         at_bottom_i,
  input  logic         commit_top_i,
  input  logic [3:0]   wgm_i,
  input  logic         wr16_i,
  input  logic [W-1:0] val16_i,
  output logic [W-1:0] active_o
);
  logic [W-1:0] buf_q;
  logic         buffered, commit;

  assign buffered = is_buffered(wgm_i);
  assign commit   = buffered && tick_i && (commit_top_i ? at_top_i : at_bottom_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q    <= '0;
      active_o <= '0;
    end else begin
      if (wr16_i) buf_q <= val16_i;
      if (wr16_i && !buffered) active_o <= val16_i;
      else if (commit)         active_o <= buf_q;
    end
  end
endmodule

// File: rtl/ocu_flag.sv
module ocu_flag #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] active_i,
  input  logic         ack_i,
  input  logic         sw_clr_i,
  input  logic         ie_i,
  output logic         match_o,
  output logic         flag_o,
  output logic         irq_o
);
  logic hit_q, set;

  assign match_o = tick_i && (cnt_i == active_i);
  assign set     = tick_i && hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_q  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (tick_i) hit_q <= match_o;
      if (set)                     flag_o <= 1'b1;
      else if (ack_i || sw_clr_i)  flag_o <= 1'b0;
    end
  end

  assign irq_o = flag_o && ie_i;
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel #(
  parameter int BUS_W   = 8,
  parameter bit TOP_SRC = 1'b1,
  localparam int W = 2 * BUS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [W-1:0]     cnt_i,
  input  logic             at_top_i,
  input  logic             at_bottom_i,
  input  logic [3:0]       wgm_i,
  input  logic             commit_top_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [BUS_W-1:0] wr_data_i,
  input  logic             irq_ack_i,
  output logic             match_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic [W-1:0]     cmp_o,
  output logic [W-1:0]     top_o
);
  logic         wr16, sw_clr, ie;
  logic [W-1:0] val16;

  ocu_regif #(.BUS_W(BUS_W)) u_regif (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .wr16_o(wr16), .val16_o(val16), .sw_clr_o(sw_clr), .ie_o(ie)
  );

  ocu_buffer #(.W(W)) u_buffer (
    .clk_i, .rst_ni, .tick_i, .at_top_i, .at_bottom_i, .commit_top_i, .wgm_i,
    .wr16_i(wr16), .val16_i(val16), .active_o(cmp_o)
  );

  ocu_flag #(.W(W)) u_flag (
    .clk_i, .rst_ni, .tick_i, .cnt_i, .active_i(cmp_o),
    .ack_i(irq_ack_i), .sw_clr_i(sw_clr), .ie_i(ie),
    .match_o, .flag_o, .irq_o
  );

  generate
    if (TOP_SRC) begin : g_top
      assign top_o = cmp_o;
    end else begin : g_notop
      assign top_o = '0;
    end
  endgenerate
endmodule

// File: rtl/ocu_channel_chk.sv
module ocu_channel_chk import ocu_pkg::*; #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         at_top_i,
  input logic         at_bottom_i,
  input logic         commit_top_i,
  input logic [3:0]   wgm_i,
  input logic         wr_en_i,
  input logic [1:0]   wr_addr_i,
  input logic [7:0]   wr_data_i,
  input logic         irq_ack_i,
  input logic         match_o,
  input logic         flag_o,
  input logic         irq_o,
  input logic [W-1:0] cmp_o
);
  logic pend_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (tick_i) pend_q <= match_o;
  end

  AST_MATCH_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |-> tick_i); // R2
  AST_FLAG_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && pend_q) |=> flag_o); // R3
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !(tick_i && pend_q)) |=> !flag_o); // R5
  AST_DIRECT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_buffered(wgm_i) && wr_en_i && wr_addr_i == ADR_LO)
      |=> cmp_o[7:0] == $past(wr_data_i)); // R9
  AST_BUF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_buffered(wgm_i) && !(tick_i && (commit_top_i ? at_top_i : at_bottom_i)))
      |=> $stable(cmp_o)); // R10
endmodule

bind ocu_channel ocu_channel_chk #(.W(W)) u_chk (
  .clk_i, .rst_ni, .tick_i, .at_top_i, .at_bottom_i, .commit_top_i, .wgm_i,
  .wr_en_i, .wr_addr_i, .wr_data_i, .irq_ack_i, .match_o, .flag_o, .irq_o, .cmp_o
);

// File: tb/tb_ocu_channel.sv
module tb_ocu_channel;
  logic        clk = 0, rst_ni = 0;
  logic        tick_i = 0, at_top_i = 0, at_bottom_i = 0, commit_top_i = 1;
  logic [15:0] cnt_i = 0;
  logic [3:0]  wgm_i = 0;
  logic        wr_en_i = 0, irq_ack_i = 0;
  logic [1:0]  wr_addr_i = 0;
  logic [7:0]  wr_data_i = 0;
  logic        match_o, flag_o, irq_o;
  logic [15:0] cmp_o, top_o;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ocu_channel dut (
    .clk_i(clk), .rst_ni, .tick_i, .cnt_i, .at_top_i, .at_bottom_i, .wgm_i,
    .commit_top_i, .wr_en_i, .wr_addr_i, .wr_data_i, .irq_ack_i,
    .match_o, .flag_o, .irq_o, .cmp_o, .top_o
  );

  typedef struct packed { logic [15:0] cnt; logic tick; logic exp; } vec_t;
  localparam vec_t VEC [8] = '{
    '{16'h1234, 1'b1, 1'b1}, '{16'h1233, 1'b1, 1'b0},
    '{16'h1235, 1'b1, 1'b0}, '{16'h1234, 1'b0, 1'b0},
    '{16'h0000, 1'b1, 1'b0}, '{16'hFFFF, 1'b1, 1'b0},
    '{16'h3412, 1'b1, 1'b0}, '{16'h1234, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1; wr_addr_i = a; wr_data_i = d;
    step();
    wr_en_i = 0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #13; rst_ni = 1; step();
    // R1 reset state
    chk("R1 cmp", cmp_o, 0); chk("R1 flag", flag_o, 0);
    chk("R1 irq", irq_o, 0); chk("R1 top", top_o, 0);

    // R8 high byte alone, R9 direct load in mode 0
    wr(1, 8'h12);
    chk("R8 hi byte held", cmp_o, 16'h0000);
    wr(0, 8'h34);
    chk("R9 direct load", cmp_o, 16'h1234);
    chk("R12 top source", top_o, 16'h1234);

    // R2 vector table
    foreach (VEC[i]) begin
      cnt_i = VEC[i].cnt; tick_i = VEC[i].tick; #1;
      chk("R2 match", match_o, VEC[i].exp);
      step();
    end
    // flush the pending hit, clear flag
    cnt_i = 16'h0001; tick_i = 1; step(); step();
    wr(2, 8'h01);
    chk("R6 sw clear", flag_o, 0);

    // R3 flag one tick after match
    cnt_i = 16'h1234; step();
    chk("R3 not same tick", flag_o, 0);
    cnt_i = 16'h0001; step();
    chk("R3 flag set", flag_o, 1);
    // R6 write of 0 ignored
    wr(2, 8'h00);
    chk("R6 zero write ignored", flag_o, 1);
    // R4 enable gating
    chk("R4 irq off", irq_o, 0);
    wr(3, 8'h01);
    chk("R4 irq on", irq_o, 1);
    // R5 ack
    irq_ack_i = 1; step(); irq_ack_i = 0;
    chk("R5 ack clears", flag_o, 0);
    chk("R4 irq follows", irq_o, 0);

    // R7 set beats clear: keep matching so set fires every tick
    cnt_i = 16'h1234; step(); step();
    chk("R7 pre", flag_o, 1);
    wr(2, 8'h01);
    chk("R7 set wins sw", flag_o, 1);
    irq_ack_i = 1; step(); irq_ack_i = 0;
    chk("R7 set wins ack", flag_o, 1);
    cnt_i = 16'h0001; step(); step();
    wr(2, 8'h01);

    // R10/R11 buffered, commit at top (mode 14)
    wgm_i = 4'd14; commit_top_i = 1; tick_i = 0;
    wr(1, 8'h0A); wr(0, 8'h0B);
    chk("R10 write buffered", cmp_o, 16'h1234);
    at_bottom_i = 1; tick_i = 1; step(); at_bottom_i = 0;
    chk("R11 wrong extreme", cmp_o, 16'h1234);
    at_top_i = 1; tick_i = 0; step();
    chk("R11 no tick", cmp_o, 16'h1234);
    tick_i = 1; step(); at_top_i = 0;
    chk("R10 commit top", cmp_o, 16'h0A0B);

    // commit at bottom (mode 5)
    wgm_i = 4'd5; commit_top_i = 0;
    wr(1, 8'h0C); wr(0, 8'h0D);
    at_top_i = 1; step(); at_top_i = 0;
    chk("R11 top ignored", cmp_o, 16'h0A0B);
    at_bottom_i = 1; step(); at_bottom_i = 0;
    chk("R10 commit bottom", cmp_o, 16'h0C0D);
    chk("R12 top tracks", top_o, 16'h0C0D);

    // R9 CTC code 12 bypasses buffer
    wgm_i = 4'd12;
    wr(1, 8'h55); wr(0, 8'hAA);
    chk("R9 ctc direct", cmp_o, 16'h55AA);

    // R1 reset again
    rst_ni = 0; #1;
    chk("R1 async reset", cmp_o, 0);
    chk("R1 async flag", flag_o, 0);
    finish_run();
  end
endmodule